// File: doc/BRIEF.md
# Operand-Two Shifter with Carry

This block produces the second ALU operand for a 32-bit data-processing instruction, together with the carry that the shifter hands to the flag logic. It is purely combinational. Its inputs are the instruction word, the value of the register that supplies the operand, the value of a register that may supply a shift count, and the current carry flag. From these it forms the 32-bit operand and the shifter carry.

There are two ways to form the operand. In the first, an 8-bit constant held in the instruction is rotated right. In the second, a register value is shifted by a count that comes either from the instruction or from a register. The block also decodes the instruction class, the 4-bit opcode and the flag-update bit, and passes them on for the stages that follow. A shift count of zero, a count of exactly the word width, and a count above the word width each have their own rule for the result and for the carry.

Top module: `op2_shifter`

## Requirements
- R1: `is_dp` is 1 exactly when instr[27:26] is 00. `opcode` equals instr[24:21], and `set_flags` equals instr[20], whatever the other fields hold.
- R2: When instr[25] is 1, `op2` is the zero-extended byte instr[7:0] rotated right by twice the value of instr[11:8]. A rotate field of zero gives the byte unchanged.
- R3: In the constant form, `c_out` equals `c_in` when instr[11:8] is zero. Otherwise `c_out` equals bit 31 of `op2`.
- R4: When instr[25] is 0, the shift type is instr[6:5], with 00 for logical left, 01 for logical right, 10 for arithmetic right and 11 for rotate right. The count is instr[11:7] when instr[4] is 0. When instr[4] is 1, the count is the low 8 bits of `cnt_src` and the upper bits of `cnt_src` are ignored.
- R5: In the register form, a count of zero gives `op2` = `opnd` and `c_out` = `c_in` for every shift type.
- R6: A logical left shift by n, with n from 1 to 31, gives `opnd << n`, and the carry is opnd[32-n].
- R7: A logical left shift by exactly 32 gives zero with the carry equal to opnd[0]. A count above 32 gives zero with a carry of 0.
- R8: A logical right shift by n from 1 to 31 gives `opnd >> n` with the carry opnd[n-1]. At exactly 32 the result is zero and the carry is opnd[31]. Above 32, the result and the carry are both zero.
- R9: An arithmetic right shift by n from 1 to 31 fills from the sign bit, and the carry is opnd[n-1]. At 32 or more, every result bit and the carry all equal opnd[31].
- R10: A rotate right by a nonzero count uses the count modulo 32. If the count is a nonzero multiple of 32, `op2` = `opnd` and the carry is opnd[31]. Otherwise the carry is opnd[(n mod 32)-1].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| opnd | input | DW | Value of the operand register |
| cnt_src | input | DW | Value of the shift-count register |
| c_in | input | 1 | Current carry flag |
| op2 | output | DW | Second operand |
| c_out | output | 1 | Shifter carry |
| is_dp | output | 1 | Instruction is in the data-processing class |
| opcode | output | 4 | ALU opcode field |
| set_flags | output | 1 | Flag-update request |

## Verification
The bench builds the block with its default parameters: a 32-bit word and an 8-bit count. With these values the boundary counts 0, 1, 31, 32, 33 and 255 can all be driven from the count register. Each of the four shift types is run at each of these counts, and also at instruction-field counts from 0 to 31. Every constant rotate is exercised as well. The expected values come from a model that shifts one bit at a time, and the bench compares them against the block's outputs on random operands.

// File: rtl/op2_shifter.sv
module op2_shifter #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic [31:0]   instr,
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] cnt_src,
  input  logic          c_in,
  output logic [DW-1:0] op2,
  output logic          c_out,
  output logic          is_dp,
  output logic [3:0]    opcode,
  output logic          set_flags
);
  localparam int NW = $clog2(DW);
  localparam logic [1:0] T_LSL = 2'd0, T_LSR = 2'd1, T_ASR = 2'd2, T_ROR = 2'd3;

  assign is_dp     = (instr[27:26] == 2'b00);
  assign opcode    = instr[24:21];
  assign set_flags = instr[20];

  logic [DW-1:0]   imm_ext;
  logic [2*DW-1:0] imm_dbl;
  logic [NW-1:0]   rot2;
  logic [DW-1:0]   imm_rot;
  assign imm_ext = {{(DW-8){1'b0}}, instr[7:0]};
  assign rot2    = NW'({instr[11:8], 1'b0});
  assign imm_dbl = {imm_ext, imm_ext} >> rot2;
  assign imm_rot = imm_dbl[DW-1:0];

  logic [CW-1:0]   amt;
  logic [NW-1:0]   r, nr, rm1;
  logic [1:0]      styp;
  logic            a_zero, a_eq, a_big;
  logic [2*DW-1:0] ror_dbl;
  logic [DW-1:0]   sh;
  logic            sc;

  assign amt     = instr[4] ? cnt_src[CW-1:0] : {{(CW-5){1'b0}}, instr[11:7]};
  assign styp    = instr[6:5];
  assign r       = amt[NW-1:0];
  assign nr      = NW'(0) - r;
  assign rm1     = r - NW'(1);
  assign a_zero  = (amt == '0);
  assign a_eq    = (amt == CW'(DW));
  assign a_big   = (amt > CW'(DW));
  assign ror_dbl = {opnd, opnd} >> r;

  always_comb begin
    sh = opnd;
    sc = c_in;
    if (!a_zero) begin
      unique case (styp)
        T_LSL: begin
          if (a_eq)       begin sh = '0;         sc = opnd[0]; end
          else if (a_big) begin sh = '0;         sc = 1'b0;    end
          else            begin sh = opnd << r;  sc = opnd[nr]; end
        end
        T_LSR: begin
          if (a_eq)       begin sh = '0;         sc = opnd[DW-1]; end
          else if (a_big) begin sh = '0;         sc = 1'b0;       end
          else            begin sh = opnd >> r;  sc = opnd[rm1];  end
        end
        T_ASR: begin
          if (a_eq || a_big) begin sh = {DW{opnd[DW-1]}}; sc = opnd[DW-1]; end
          else begin sh = DW'($signed(opnd) >>> r); sc = opnd[rm1]; end
        end
        default: begin
          if (r == '0) begin sh = opnd;              sc = opnd[DW-1]; end
          else         begin sh = ror_dbl[DW-1:0];   sc = opnd[rm1];  end
        end
      endcase
    end
  end

  assign op2   = instr[25] ? imm_rot : sh;
  assign c_out = instr[25] ? ((instr[11:8] == 4'd0) ? c_in : imm_rot[DW-1]) : sc;

  always_comb begin
    if (!$isunknown({instr, opnd, cnt_src, c_in})) begin
      if (instr[25] && instr[11:8] == 4'd0)
        p_imm_unrotated_r2: assert (op2 == imm_ext && c_out == c_in);
      if (instr[25] && instr[11:8] != 4'd0)
        p_imm_carry_top_r3: assert (c_out == op2[DW-1]);
      if (!instr[25] && a_zero)
        p_zero_count_keeps_r5: assert (op2 == opnd && c_out == c_in);
      if (!instr[25] && styp == T_LSL && a_big)
        p_lsl_beyond_clears_r7: assert (op2 == '0 && !c_out);
      if (!instr[25] && styp == T_ASR && (a_eq || a_big))
        p_asr_sign_fill_r9: assert (op2 == {DW{opnd[DW-1]}} && c_out == opnd[DW-1]);
      if (!instr[25] && styp == T_ROR && !a_zero && r == '0)
        p_ror_full_turn_r10: assert (op2 == opnd && c_out == opnd[DW-1]);
    end
  end
endmodule

// File: tb/sim_op2_shifter.sv
module sim_op2_shifter;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr = '0, opnd = '0, cnt_src = '0;
  logic        c_in = 1'b0;
  logic [31:0] op2;
  logic        c_out, is_dp, set_flags;
  logic [3:0]  opcode;

  op2_shifter u0 (.instr(instr), .opnd(opnd), .cnt_src(cnt_src), .c_in(c_in),
                  .op2(op2), .c_out(c_out), .is_dp(is_dp), .opcode(opcode),
                  .set_flags(set_flags));

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] q_op[$];
  logic        q_c[$], q_dp[$], q_s[$];
  logic [3:0]  q_opc[$];
  string       q_tag[$];

  task automatic ref_shift(input logic [31:0] x, input logic [1:0] t, input int n,
                           input logic ci, output logic [31:0] res, output logic co);
    res = x; co = ci;
    for (int i = 0; i < n; i++) begin
      case (t)
        2'd0: begin co = res[31]; res = res << 1; end
        2'd1: begin co = res[0];  res = res >> 1; end
        2'd2: begin co = res[0];  res = {res[31], res[31:1]}; end
        default: begin co = res[0]; res = {res[0], res[31:1]}; end
      endcase
    end
  endtask

  task automatic drive(input logic [31:0] i_w, input logic [31:0] o_v,
                       input logic [31:0] c_v, input logic ci, input string tag);
    logic [31:0] e_op;
    logic        e_c;
    int          n;
    @(posedge clk); #1;
    instr = i_w; opnd = o_v; cnt_src = c_v; c_in = ci;
    if (i_w[25]) ref_shift({24'd0, i_w[7:0]}, 2'd3, 2 * int'(i_w[11:8]), ci, e_op, e_c);
    else begin
      n = i_w[4] ? int'(c_v[7:0]) : int'(i_w[11:7]);
      ref_shift(o_v, i_w[6:5], n, ci, e_op, e_c);
    end
    q_op.push_back(e_op); q_c.push_back(e_c);
    q_dp.push_back(i_w[27:26] == 2'b00); q_opc.push_back(i_w[24:21]);
    q_s.push_back(i_w[20]); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (q_op.size() > 0) begin
      logic [31:0] e_op; logic e_c, e_dp, e_s; logic [3:0] e_opc; string tg;
      e_op = q_op.pop_front(); e_c = q_c.pop_front(); e_dp = q_dp.pop_front();
      e_opc = q_opc.pop_front(); e_s = q_s.pop_front(); tg = q_tag.pop_front();
      total++;
      if (op2 !== e_op || c_out !== e_c || is_dp !== e_dp || opcode !== e_opc || set_flags !== e_s) begin
        bad++;
        $display("FAIL %s: got op2=%h c=%b dp=%b opc=%h s=%b exp op2=%h c=%b dp=%b opc=%h s=%b",
                 tg, op2, c_out, is_dp, opcode, set_flags, e_op, e_c, e_dp, e_opc, e_s);
      end
    end
  end

  function automatic logic [31:0] mk_reg(logic [1:0] cls, logic [3:0] opc, logic s,
                                         logic [4:0] a5, logic [1:0] t, logic creg);
    return {4'hE, cls, 1'b0, opc, s, 4'h1, 4'h2, a5, t, creg, 4'h3};
  endfunction

  function automatic string tag_for(logic [1:0] t, int n);
    if (n == 0) return "R4 R5";
    case (t)
      2'd0: return (n < 32) ? "R4 R6" : "R4 R7";
      2'd1: return "R4 R8";
      2'd2: return "R4 R9";
      default: return "R4 R10";
    endcase
  endfunction

  initial begin
    int cnts[6] = '{0, 1, 31, 32, 33, 255};
    #2;
    // R1 R5: reset-like idle state, all-zero instruction is a data-processing LSL #0
    drive(32'h0, 32'h0, 32'h0, 1'b0, "R1 R5 idle");
    drive(32'hE7F0_0000, 32'h1234_5678, 0, 1'b1, "R1 non-dp class");
    drive(32'hEBF0_0000, 32'h8000_0001, 0, 1'b0, "R1 non-dp class");
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 6; k++)
        for (int rep = 0; rep < 3; rep++) begin
          logic [31:0] ov, hi;
          ov = (rep == 0) ? 32'h8000_0001 : $urandom;
          hi = {$urandom} & 32'hFFFF_FF00;
          drive(mk_reg(2'b00, 4'($urandom), 1'($urandom), 5'($urandom), 2'(t), 1'b1),
                ov, hi | 32'(cnts[k]), 1'($urandom), tag_for(2'(t), cnts[k]));
        end
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 32; a++)
        drive(mk_reg(2'b00, 4'(a), 1'(a), 5'(a), 2'(t), 1'b0), $urandom,
              $urandom, 1'($urandom), tag_for(2'(t), a));
    for (int rt = 0; rt < 16; rt++)
      for (int rep = 0; rep < 2; rep++) begin
        logic [31:0] iw;
        iw = {4'hE, 2'b00, 1'b1, 4'($urandom), 1'($urandom), 8'h45, 4'(rt), 8'($urandom)};
        if (rep == 0) iw[7:0] = 8'h81;
        drive(iw, $urandom, $urandom, 1'(rep), rt == 0 ? "R2 R3 rot0" : "R2 R3");
      end
    for (int k = 0; k < 300; k++) begin
      logic [31:0] iw;
      iw = $urandom;
      drive(iw, $urandom, $urandom, 1'($urandom), "R1 R2 R4 random");
    end
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule